// File: doc/BRIEF.md
# E1/T1 All-Ones Alarm Window Detector

This block watches a recovered E1 or T1 bit stream and raises an alarm indication signal (AIS) flag when the line carries an all-ones pattern. It cuts the stream into back-to-back windows of a fixed number of valid bits. It counts the zeros seen in each window and takes its decision only when a window closes. The mode sets the window length and the zero threshold: 512 bits (250 µs) in E1 mode and 4632 bits (3 ms) in T1 mode.

A window with fewer zeros than the mode's threshold sets the flag. A later window that reaches the threshold clears it. Because the flag moves only at window boundaries, a raised flag stays high for at least one full window. Upstream logic supplies one decoded bit per strobe of the valid input. The flag is used as a level alarm. When the mode select names neither E1 nor T1, the detector stays idle and keeps the flag low.

Top module: `ais_win_det`

## Requirements
- R1: While reset is high and in the first cycle after it, `ais_o` is 0.
- R2: A window is exactly the number of strobed bits for the mode: 512 for E1 (`mode_i` = 2'b01) and 4632 for T1 (`mode_i` = 2'b10). The flag can change only in the cycle after the last bit of a window is strobed.
- R3: In E1 mode, a window holding 2 or fewer zeros sets `ais_o` at its boundary.
- R4: In E1 mode, a window holding 3 or more zeros leaves a clear flag clear.
- R5: In E1 mode a set flag remains set after a window with 2 or fewer zeros. It clears after a window with 3 or more zeros.
- R6: In T1 mode, a window holding 4 or fewer zeros sets `ais_o`, and a window holding 5 or more leaves a clear flag clear.
- R7: In T1 mode a set flag remains set after a window with 4 or fewer zeros. It clears after a window with 5 or more zeros.
- R8: Cycles with `bit_vld_i` low are ignored. They add neither to the bit position nor to the zero count, whatever `bit_i` carries.
- R9: While `mode_i` is 2'b00 or 2'b11, `ais_o` is 0 one cycle later and stays 0 whatever bits arrive.
- R10: Any change of `mode_i` clears `ais_o` in the next cycle and restarts the window from its first bit.
- R11: Between window boundaries, with the mode unchanged, `ais_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 2'b01 E1, 2'b10 T1, other values idle |
| bit_vld_i | input | 1 | Strobe: `bit_i` carries a line bit this cycle |
| bit_i | input | 1 | Recovered data bit |
| ais_o | output | 1 | Alarm flag, updated at window boundaries |

## Verification
Each mode is driven with windows whose zero count sits exactly on either side of its threshold: 2 against 3 in E1, and 4 against 5 in T1. Each count is applied from both flag states, so the set rule and the clear rule are told apart. The zeros are placed at the start of a window in some runs and at its end in others, which exposes a count that is cleared or sampled one bit early. The flag is also sampled just before the last bit of each window, which shows whether the boundary falls too early. Separate stimuli cover these cases:
- strobe gaps that carry zeros;
- a partial window followed by a mode toggle, which proves the window restarts;
- both idle encodings fed with zero-free data, where a detector that keeps counting would raise the flag.

// File: rtl/ais_pkg.sv
package ais_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_E1   = 2'b01,
        MODE_T1   = 2'b10,
        MODE_RSVD = 2'b11
    } ais_mode_e;

    // Control bundle shared by the window and count stages.
    typedef struct packed {
        logic active;   // E1 or T1 selected
        logic t1;       // T1 limits apply
        logic restart;  // mode moved since last cycle
        logic clr;      // hold counters and flag at zero
    } ais_ctl_t;

    function automatic logic mode_is_active(logic [1:0] m);
        return (m == MODE_E1) || (m == MODE_T1);
    endfunction

    function automatic int pick(logic t1, int e1_val, int t1_val);
        return t1 ? t1_val : e1_val;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ais_win_ctr.sv
module ais_win_ctr
    import ais_pkg::*;
#(
    parameter int E1_WIN = 512,
    parameter int T1_WIN = 4632,
    parameter int POS_W  = 13
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic             t1_sel_i,
    input  logic             bit_vld_i,
    output logic [POS_W-1:0] pos_o,
    output logic             win_end_o
);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] last_pos;

    assign last_pos  = POS_W'(pick(t1_sel_i, E1_WIN, T1_WIN) - 1);
    assign win_end_o = !clr_i && bit_vld_i && (pos_q == last_pos);
    assign pos_o     = pos_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            pos_q <= '0;
        end else if (bit_vld_i) begin
            pos_q <= win_end_o ? '0 : pos_q + 1'b1;
        end
    end

endmodule

// File: rtl/ais_zero_ctr.sv
module ais_zero_ctr
    import ais_pkg::*;
#(
    parameter int E1_THR = 3,
    parameter int T1_THR = 5,
    parameter int ZC_W   = 3
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            clr_i,
    input  logic            t1_sel_i,
    input  logic            bit_vld_i,
    input  logic            bit_i,
    input  logic            win_end_i,
    output logic [ZC_W-1:0] zeros_o
);

    logic [ZC_W-1:0] cnt_q;
    logic [ZC_W-1:0] thr;
    logic [ZC_W-1:0] sum;
    logic            inc;

    assign thr = ZC_W'(pick(t1_sel_i, E1_THR, T1_THR));
    assign inc = bit_vld_i && !bit_i;
    assign sum = cnt_q + ZC_W'(inc);
    // Window total including the bit on the input now, held at the threshold.
    assign zeros_o = (sum > thr) ? thr : sum;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i || win_end_i) begin
            cnt_q <= '0;
        end else if (bit_vld_i) begin
            cnt_q <= zeros_o;
        end
    end

endmodule

// File: rtl/ais_flag.sv
module ais_flag
    import ais_pkg::*;
#(
    parameter int E1_THR = 3,
    parameter int T1_THR = 5,
    parameter int ZC_W   = 3
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            clr_i,
    input  logic            t1_sel_i,
    input  logic            win_end_i,
    input  logic [ZC_W-1:0] zeros_i,
    output logic            ais_o
);

    logic [ZC_W-1:0] thr;
    logic            ais_q;

    assign thr   = ZC_W'(pick(t1_sel_i, E1_THR, T1_THR));
    assign ais_o = ais_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            ais_q <= 1'b0;
        end else if (win_end_i) begin
            ais_q <= (zeros_i < thr);
        end
    end

endmodule

// File: rtl/ais_win_det.sv
module ais_win_det
    import ais_pkg::*;
#(
    parameter int E1_WIN = 512,
    parameter int T1_WIN = 4632,
    parameter int E1_THR = 3,
    parameter int T1_THR = 5
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] mode_i,
    input  logic       bit_vld_i,
    input  logic       bit_i,
    output logic       ais_o
);

    localparam int WIN_MAX = imax(E1_WIN, T1_WIN);
    localparam int POS_W   = $clog2(WIN_MAX);
    localparam int THR_MAX = imax(E1_THR, T1_THR);
    localparam int ZC_W    = $clog2(THR_MAX + 2);

    logic [1:0]       mode_q;
    ais_ctl_t         ctl;
    logic [POS_W-1:0] pos_q;
    logic             win_end;
    logic [ZC_W-1:0]  win_zeros;

    always_ff @(posedge clk_i) begin
        mode_q <= mode_i;
    end

    always_comb begin
        ctl.active  = mode_is_active(mode_i);
        ctl.t1      = (mode_i == MODE_T1);
        ctl.restart = !rst_i && (mode_i != mode_q);
        ctl.clr     = ctl.restart || !ctl.active;
    end

    ais_win_ctr #(
        .E1_WIN (E1_WIN),
        .T1_WIN (T1_WIN),
        .POS_W  (POS_W)
    ) win_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clr_i     (ctl.clr),
        .t1_sel_i  (ctl.t1),
        .bit_vld_i (bit_vld_i),
        .pos_o     (pos_q),
        .win_end_o (win_end)
    );

    ais_zero_ctr #(
        .E1_THR (E1_THR),
        .T1_THR (T1_THR),
        .ZC_W   (ZC_W)
    ) zc_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clr_i     (ctl.clr),
        .t1_sel_i  (ctl.t1),
        .bit_vld_i (bit_vld_i),
        .bit_i     (bit_i),
        .win_end_i (win_end),
        .zeros_o   (win_zeros)
    );

    ais_flag #(
        .E1_THR (E1_THR),
        .T1_THR (T1_THR),
        .ZC_W   (ZC_W)
    ) flag_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .clr_i     (ctl.clr),
        .t1_sel_i  (ctl.t1),
        .win_end_i (win_end),
        .zeros_i   (win_zeros),
        .ais_o     (ais_o)
    );

endmodule

// File: rtl/ais_win_det_chk.sv
module ais_win_det_chk #(
    parameter int E1_WIN = 512,
    parameter int T1_WIN = 4632,
    parameter int POS_W  = 13
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [1:0]       mode_i,
    input logic             bit_vld_i,
    input logic             ais_o,
    input logic             win_end,
    input logic [POS_W-1:0] pos_q
);

    // R9
    idle_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(mode_i == 2'b01 || mode_i == 2'b10) |=> !ais_o);

    // R10
    mode_chg_clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i != $past(mode_i)) |=> !ais_o);

    // R11
    hold_between_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($stable(mode_i) && !win_end) |=> $stable(ais_o));

    // R2
    e1_pos_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'b01 && $stable(mode_i)) |-> (int'(pos_q) < E1_WIN));

    // R2
    t1_pos_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'b10 && $stable(mode_i)) |-> (int'(pos_q) < T1_WIN));

    // R8
    gap_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bit_vld_i && $stable(mode_i)) |=> $stable(pos_q));

endmodule

bind ais_win_det ais_win_det_chk #(
    .E1_WIN (E1_WIN),
    .T1_WIN (T1_WIN),
    .POS_W  (POS_W)
) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .mode_i    (mode_i),
    .bit_vld_i (bit_vld_i),
    .ais_o     (ais_o),
    .win_end   (win_end),
    .pos_q     (pos_q)
);

// File: tb/ais_win_det_tb_top.sv
module ais_win_det_tb_top;

    localparam int E1N = 512;
    localparam int T1N = 4632;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode;
    logic       bit_vld;
    logic       bit_v;
    logic       ais;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    always #4 clk = ~clk;

    ais_win_det dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .mode_i    (mode),
        .bit_vld_i (bit_vld),
        .bit_i     (bit_v),
        .ais_o     (ais)
    );

    task automatic check(logic act, logic exp, string req, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // One window of back-to-back strobes; zeros at start or end.
    task automatic feed(int nbits, int nz, bit zeros_last,
                        logic exp_before, logic exp_after, string req);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            if (i == nbits - 1) check(ais, exp_before, req, "before last bit");
            bit_vld = 1'b1;
            if (zeros_last) bit_v = (i < nbits - nz) ? 1'b1 : 1'b0;
            else            bit_v = (i < nz) ? 1'b0 : 1'b1;
        end
        @(negedge clk);
        bit_vld = 1'b0;
        bit_v   = 1'b1;
        check(ais, exp_after, req, "after window");
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode    = m;
        bit_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; mode = 2'b01; bit_vld = 1'b0; bit_v = 1'b1;
        repeat (4) @(negedge clk);
        check(ais, 1'b0, "R1", "during reset");
        rst = 1'b0;
        @(negedge clk);
        check(ais, 1'b0, "R1", "after reset");
    endtask

    task automatic t_e1_rules();
        feed(E1N, 2, 1'b0, 1'b0, 1'b1, "R2 R3");
        feed(E1N, 2, 1'b1, 1'b1, 1'b1, "R5 stay");
        feed(E1N, 0, 1'b0, 1'b1, 1'b1, "R5 ones");
        feed(E1N, 3, 1'b1, 1'b1, 1'b0, "R5 clear");
        feed(E1N, 3, 1'b0, 1'b0, 1'b0, "R4");
        feed(E1N, 9, 1'b1, 1'b0, 1'b0, "R4 many");
    endtask

    // Invalid cycles carry zeros that must be ignored.
    task automatic t_gaps();
        for (int i = 0; i < E1N; i++) begin
            @(negedge clk);
            if (i == E1N - 1) check(ais, 1'b0, "R8", "before last strobe");
            bit_vld = 1'b1;
            bit_v   = (i < 1) ? 1'b0 : 1'b1;
            @(negedge clk);
            bit_vld = 1'b0;
            bit_v   = 1'b0;
        end
        check(ais, 1'b1, "R8", "after gapped window");
        bit_v = 1'b1;
        feed(E1N, 3, 1'b0, 1'b1, 1'b0, "R8 R5");
    endtask

    task automatic t_t1_rules();
        feed(E1N, 0, 1'b0, 1'b0, 1'b1, "R3 setup");
        set_mode(2'b10);
        check(ais, 1'b0, "R10", "flag after mode change");
        feed(T1N, 4, 1'b0, 1'b0, 1'b1, "R2 R6");
        feed(T1N, 4, 1'b1, 1'b1, 1'b1, "R7 stay");
        feed(T1N, 5, 1'b0, 1'b1, 1'b0, "R7 clear");
        feed(T1N, 5, 1'b1, 1'b0, 1'b0, "R6 stay clear");
    endtask

    task automatic t_restart();
        set_mode(2'b01);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            bit_vld = 1'b1;
            bit_v   = 1'b1;
        end
        set_mode(2'b10);
        set_mode(2'b01);
        feed(E1N, 0, 1'b0, 1'b0, 1'b1, "R10 restart");
    endtask

    task automatic t_idle();
        set_mode(2'b00);
        check(ais, 1'b0, "R9", "idle clears flag");
        feed(600, 0, 1'b0, 1'b0, 1'b0, "R9 idle 00");
        set_mode(2'b11);
        feed(600, 0, 1'b0, 1'b0, 1'b0, "R9 idle 11");
    endtask

    initial begin
        t_reset();
        t_e1_rules();
        t_gaps();
        t_t1_rules();
        t_restart();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule